// File: doc/BRIEF.md
# Line-Aligned Video Dual-Clock Buffer

This block carries a 10-bit video word stream from the recovered pixel clock to an unrelated read clock. Each word is stored with four sideband flags: horizontal blanking (H), vertical blanking (V), field (F) and ancillary-data detect (ANC). The flags leave the memory in the same read cycle as the word they were written with. This keeps the timing and ancillary indications locked to the delayed data, not to the incoming stream.

The addresses on both sides follow line timing and do not run free. On the write side, a line-start strobe marks the first zero word of the start-of-active-video sequence. That word is written to location zero, and each later word goes to the next location. On the read side, the read clock steps one address per cycle. A single-cycle low pulse on the alignment input moves reading back to location zero. The position of that pulse, measured against the incoming line, sets the line-relative delay through the block. It also moves the data onto the read clock's phase.

Top module: `vid_line_fifo`

## Requirements
- R1: While `rst_ni` is low, `rd_data_o` and the four output flags are 0. The reset takes effect without waiting for a clock edge.
- R2: A pixel-clock edge with `wr_sol_i` high writes the current word to location 0. Each pixel-clock edge without the strobe writes to the location after the previous write.
- R3: The H, V and F inputs are stored with the word written in the same pixel cycle. When that word is read, they appear on `rd_h_o`, `rd_v_o` and `rd_f_o` in the same read cycle as it.
- R4: `rd_anc_o` is the ANC flag that was written with the word now on `rd_data_o`. It is not the ANC flag of the current input.
- R5: A read-clock rising edge that samples `rd_align_ni` low after a high sample sets the read address to 0. At the next rising edge, the word from location 0 (the first 000 of the SAV) appears on the outputs. The words from locations 1, 2, … follow, one per read cycle.
- R6: Without an alignment edge, the read address advances by one on every read-clock edge and wraps from 2047 to 0. Read index 2048 after an alignment therefore returns the word at location 0 again.
- R7: The write address wraps from 2047 to 0 when no line-start strobe arrives. In a line longer than 2048 words, word k is stored at location k mod 2048.
- R8: Holding `rd_align_ni` low for a second read cycle has no effect. Only the high-to-low sample realigns, and the output sequence continues 0, 1, 2, … without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Recovered pixel clock, write domain |
| rd_clk_i | input | 1 | External read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_sol_i | input | 1 | Line-start strobe, high on the SAV first-000 word |
| wr_data_i | input | 10 | Incoming video word |
| wr_h_i | input | 1 | Incoming horizontal timing flag |
| wr_v_i | input | 1 | Incoming vertical timing flag |
| wr_f_i | input | 1 | Incoming field flag |
| wr_anc_i | input | 1 | Incoming ancillary-detect flag |
| rd_align_ni | input | 1 | Active-low read alignment pulse |
| rd_data_o | output | 10 | Video word read out |
| rd_h_o | output | 1 | H flag of the word read out |
| rd_v_o | output | 1 | V flag of the word read out |
| rd_f_o | output | 1 | F flag of the word read out |
| rd_anc_o | output | 1 | ANC flag of the word read out |

## Verification
The bench writes repeating lines of several lengths and patterns on the 10 ns pixel clock and reads them on a 13 ns clock. After each alignment pulse it compares every word and its flags against a line model.

Several corner cases are targeted:
- An off-by-one read latency would show every word shifted by one index, starting with a nonzero first word.
- A level-sensitive alignment input would restart the sequence when the pulse is held for two cycles.
- A write pointer that saturates would corrupt the words near the end of lines longer than the memory.
- A read pointer that does not wrap would fail to return the line start at index 2048.

An asynchronous reset in mid-stream checks that the outputs clear at once. After release, the first line strobe restores alignment.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  localparam int unsigned DATA_W = 10;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              h;
    logic              v;
    logic              f;
    logic              anc;
  } vid_word_t;

  localparam int unsigned WORD_W = $bits(vid_word_t);
endpackage

// File: rtl/vlf_wr_ctrl.sv
module vlf_wr_ctrl #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sol_i,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  // line start forces location zero for the current word
  assign waddr_o = sol_i ? '0 : ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= waddr_o + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/vlf_rd_ctrl.sv
module vlf_rd_ctrl #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              align_ni,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              prev_o
);
  logic              prev_q;
  logic              fall;
  logic [ADDR_W-1:0] addr_q;

  assign fall = prev_q & ~align_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      addr_q <= '0;
    end else begin
      prev_q <= align_ni;
      addr_q <= fall ? '0 : addr_q + 1'b1;
    end
  end

  assign raddr_o = addr_q;
  assign prev_o  = prev_q;
endmodule

// File: rtl/vlf_dpram.sv
module vlf_dpram #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned WIDTH  = 14
) (
  input  logic              wclk_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WIDTH-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge wclk_i) mem[waddr_i] <= wdata_i;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/vid_line_fifo.sv
module vid_line_fifo
  import vlf_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_sol_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_h_i,
  input  logic              wr_v_i,
  input  logic              wr_f_i,
  input  logic              wr_anc_i,
  input  logic              rd_align_ni,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_h_o,
  output logic              rd_v_o,
  output logic              rd_f_o,
  output logic              rd_anc_o
);
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_prev;
  vid_word_t         wr_word;
  vid_word_t         rd_word;

  assign wr_word = '{data: wr_data_i, h: wr_h_i, v: wr_v_i, f: wr_f_i, anc: wr_anc_i};

  vlf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .sol_i  (wr_sol_i),
    .waddr_o(wr_addr),
    .ptr_o  (wr_ptr)
  );

  vlf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i   (rd_clk_i),
    .rst_ni  (rst_ni),
    .align_ni(rd_align_ni),
    .raddr_o (rd_addr),
    .prev_o  (rd_prev)
  );

  vlf_dpram #(.ADDR_W(ADDR_W), .WIDTH(WORD_W)) u_mem (
    .wclk_i (wr_clk_i),
    .waddr_i(wr_addr),
    .wdata_i(wr_word),
    .rclk_i (rd_clk_i),
    .rst_ni (rst_ni),
    .raddr_i(rd_addr),
    .rdata_o(rd_word)
  );

  assign rd_data_o = rd_word.data;
  assign rd_h_o    = rd_word.h;
  assign rd_v_o    = rd_word.v;
  assign rd_f_o    = rd_word.f;
  assign rd_anc_o  = rd_word.anc;
endmodule

// File: rtl/vid_line_fifo_chk.sv
module vid_line_fifo_chk #(
  parameter int unsigned ADDR_W = 11
) (
  input logic              wr_clk_i,
  input logic              rd_clk_i,
  input logic              rst_ni,
  input logic              wr_sol_i,
  input logic              rd_align_ni,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_prev
);
  AST_SOL_TO_ONE: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_sol_i |=> (wr_ptr == ADDR_W'(1))); // R2

  AST_WR_STEP_WRAP: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    !wr_sol_i |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1))); // R7

  AST_ALIGN_ZERO: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_prev && !rd_align_ni) |=> (rd_addr == '0)); // R5

  AST_RD_STEP_WRAP: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_align_ni) |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1))); // R6

  AST_HOLD_NO_REALIGN: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (!rd_prev && !rd_align_ni) |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1))); // R8
endmodule

bind vid_line_fifo vid_line_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk_i   (wr_clk_i),
  .rd_clk_i   (rd_clk_i),
  .rst_ni     (rst_ni),
  .wr_sol_i   (wr_sol_i),
  .rd_align_ni(rd_align_ni),
  .wr_ptr     (wr_ptr),
  .rd_addr    (rd_addr),
  .rd_prev    (rd_prev)
);

// File: tb/vid_line_fifo_test.sv
module vid_line_fifo_test;
  logic       wr_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       sol = 1'b0;
  logic [9:0] din = '0;
  logic       h_i = 1'b0, v_i = 1'b0, f_i = 1'b0, anc_i = 1'b0;
  logic       align_n = 1'b1;
  logic [9:0] dout;
  logic       h_o, v_o, f_o, anc_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // requested line pattern, latched by the writer at each line start
  int  q_len = 64, q_seed = 64, q_step = 3;
  bit  q_v = 1'b0, q_f = 1'b0;

  always #5   wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  vid_line_fifo uut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_ni),
    .wr_sol_i(sol), .wr_data_i(din),
    .wr_h_i(h_i), .wr_v_i(v_i), .wr_f_i(f_i), .wr_anc_i(anc_i),
    .rd_align_ni(align_n),
    .rd_data_o(dout), .rd_h_o(h_o), .rd_v_o(v_o), .rd_f_o(f_o), .rd_anc_o(anc_o)
  );

  // {data, h, v, f, anc} of line position k
  function automatic logic [13:0] exp_word(int k, int seed, int step, bit v, bit f);
    logic [9:0] d;
    d = (k == 0) ? 10'd0 : 10'(seed + k * step);
    return {d, (k < 4), v, f, ((k % 5) == 3)};
  endfunction

  task automatic check(string tag, logic [13:0] got, logic [13:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // writer: one word per pixel clock, repeating lines
  initial begin
    int k = 0;
    int l_len = 64, l_seed = 64, l_step = 3;
    bit l_v = 1'b0, l_f = 1'b0;
    forever begin
      @(negedge wr_clk);
      if (k == 0) begin
        l_len = q_len; l_seed = q_seed; l_step = q_step; l_v = q_v; l_f = q_f;
      end
      {din, h_i, v_i, f_i, anc_i} = exp_word(k, l_seed, l_step, l_v, l_f);
      sol = (k == 0);
      k = (k + 1 >= l_len) ? 0 : k + 1;
    end
  end

  task automatic set_line(int len, int seed, int step, bit v, bit f);
    int prev = q_len;
    q_len = len; q_seed = seed; q_step = step; q_v = v; q_f = f;
    repeat (prev + 2 * len + 8) @(posedge wr_clk);
  endtask

  // align pulse held for `hold` read edges, then check indices [start, start+cnt)
  task automatic read_line(string tag, int hold, int start, int cnt);
    @(negedge rd_clk);
    align_n = 1'b0;
    @(posedge rd_clk);
    for (int j = 0; j <= start + cnt; j++) begin
      @(negedge rd_clk);
      if (j == hold - 1) align_n = 1'b1;
      if (j >= 1 && (j - 1) >= start)
        check(tag, {dout, h_o, v_o, f_o, anc_o},
              exp_word((j - 1) % 2048, q_seed, q_step, q_v, q_f));
      @(posedge rd_clk);
    end
  endtask

  typedef struct packed {
    int len; int seed; int step; bit v; bit f; int hold; int start; int cnt;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{len: 64,   seed: 'h040, step: 3, v: 1'b0, f: 1'b0, hold: 1, start: 0,    cnt: 64},
    '{len: 200,  seed: 'h155, step: 7, v: 1'b1, f: 1'b0, hold: 1, start: 0,    cnt: 40},
    '{len: 33,   seed: 'h2aa, step: 1, v: 1'b0, f: 1'b1, hold: 2, start: 0,    cnt: 33},
    '{len: 1500, seed: 'h100, step: 5, v: 1'b1, f: 1'b1, hold: 1, start: 1400, cnt: 50},
    '{len: 2100, seed: 'h003, step: 9, v: 1'b0, f: 1'b0, hold: 1, start: 2040, cnt: 8}
  };

  initial begin
    #2 rst_ni = 1'b0;
    #3 check("R1 reset", {dout, h_o, v_o, f_o, anc_o}, 14'h0);
    repeat (4) @(posedge wr_clk);
    @(negedge rd_clk) rst_ni = 1'b1;

    foreach (VECS[i]) begin
      string tag;
      set_line(VECS[i].len, VECS[i].seed, VECS[i].step, VECS[i].v, VECS[i].f);
      if (VECS[i].hold > 1)     tag = "R8 held pulse";
      else if (VECS[i].len > 2048) tag = "R7 write wrap";
      else                      tag = "R2 R3 R4 R5 line read";
      read_line(tag, VECS[i].hold, VECS[i].start, VECS[i].cnt);
    end

    // R6: read index 2048 onward returns the line start again
    set_line(300, 'h0ab, 11, 1'b1, 1'b0);
    read_line("R6 read wrap", 1, 2048, 12);

    // R1: asynchronous reset mid-stream, then recovery at next line start
    @(negedge rd_clk);
    #1 rst_ni = 1'b0;
    #2 check("R1 async clear", {dout, h_o, v_o, f_o, anc_o}, 14'h0);
    repeat (3) @(posedge rd_clk);
    #1 check("R1 held clear", {dout, h_o, v_o, f_o, anc_o}, 14'h0);
    @(negedge wr_clk) rst_ni = 1'b1;
    set_line(64, 'h040, 3, 1'b0, 1'b1);
    read_line("R2 R5 after reset", 1, 0, 20);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule